// File: doc/BRIEF.md
# Error-Driven Output Scheduler

This block is the digital decision stage for a converter in which one inductor feeds several regulated outputs. Once per switching period it takes a set of comparator results, chooses which output gets the period's energy pulse, and picks the switching mode for that pulse. The output whose regulation error is largest gets the pulse. Outputs are not served in a fixed rotation. When every output already meets its target, no output is chosen and the inductor freewheels for that period.

The inputs are all single-bit comparator results. For each pair of outputs, one bit says whether the higher-indexed output's error is strictly greater than the lower-indexed one's. For each output, one bit says its error is below the no-demand threshold. Two bits place the summed error above the upper band limit or below the lower band limit. For each output, one bit says the input supply is below a scaled copy of that output's voltage (the deep-boost condition). All of these are captured on the rising edge of the period clock. The select, mode and freewheel outputs come from the captured values only, so they hold for the whole period. The block has no data stream, so every pin is a plain control pin with no handshake.

Top module: `err_drive_sched`

## Requirements
- R1: All inputs are captured on the rising edge of `clk`. `chan_sel`, `mode_b` and `freewheel` change only at that edge and hold their values for the rest of the period.
- R2: `pair_gt` bit i*(i-1)/2+j, for j<i, is high when the error of output i is strictly greater than that of output j. For three outputs: bit0 = e1>e0, bit1 = e2>e0, bit2 = e2>e1. The output whose error is largest by these bits is selected: `chan_sel` bit k high selects output k.
- R3: When a pair bit is low, the lower-indexed output of that pair counts as not smaller. Equal largest errors therefore resolve to the lowest index.
- R4: If the pair bits form a cycle in which no output is largest, output 0 is selected.
- R5: When every `err_satisfied` bit is high, `freewheel` is 1, `chan_sel` is 0 and `mode_b` is 0. Otherwise `freewheel` is 0.
- R6: When `sum_over_hi` is high and an output is selected, `mode_b` is 1 (mode B, energize then bypass), whatever `deep_boost` says.
- R7: When `sum_under_lo` is high, `sum_over_hi` is low and an output is selected, `mode_b` is 0 (mode A, energize then de-energize).
- R8: When neither band bit is high, `mode_b` equals the `deep_boost` bit of the selected output.
- R9: When both band bits are high at once, the upper limit takes priority and `mode_b` is 1.
- R10: While `rst_n` is low, and until the first rising edge after it goes high, `chan_sel` is 0, `freewheel` is 1 and `mode_b` is 0.
- R11: Whenever `freewheel` is 0, `chan_sel` has exactly one bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Period clock, one rising edge per switching period |
| rst_n | input | 1 | Asynchronous active-low reset |
| pair_gt | input | NOUT*(NOUT-1)/2 | Pairwise error comparisons, higher index strictly greater |
| err_satisfied | input | NOUT | Per-output error below the no-demand threshold |
| sum_over_hi | input | 1 | Summed error above the upper band limit |
| sum_under_lo | input | 1 | Summed error below the lower band limit |
| deep_boost | input | NOUT | Per-output input supply below the scaled output voltage |
| chan_sel | output | NOUT | One-hot selected output, zero when freewheeling |
| mode_b | output | 1 | 0 = mode A, 1 = mode B |
| freewheel | output | 1 | No output selected this period |

## Verification
Every result is due at the first rising edge after its inputs are applied. There is exactly one register stage between the input pins and the outputs, and nothing combinational bypasses it. The bench changes inputs on the falling edge and checks the outputs twice. The first check comes a quarter period later, where the outputs must still show the previous decision. The second comes at the next falling edge, where the new decision is due. A behavioural reference model computes the expected select and mode from integer error values, or from explicit contradictory comparator patterns. The model is compared on every cycle of both directed and random stimulus.

// File: rtl/eds_pkg.sv
package eds_pkg;
  typedef enum logic {
    MODE_A = 1'b0,
    MODE_B = 1'b1
  } sw_mode_e;
endpackage

// File: rtl/eds_sampler.sv
module eds_sampler #(
  parameter int unsigned NOUT = 3,
  localparam int unsigned NPAIR = NOUT * (NOUT - 1) / 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPAIR-1:0] pair_gt_i,
  input  logic [NOUT-1:0]  sat_i,
  input  logic             hi_i,
  input  logic             lo_i,
  input  logic [NOUT-1:0]  deep_i,
  output logic [NPAIR-1:0] pair_gt_q,
  output logic [NOUT-1:0]  sat_q,
  output logic             hi_q,
  output logic             lo_q,
  output logic [NOUT-1:0]  deep_q,
  output logic             valid_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pair_gt_q <= '0;
      sat_q     <= '1;
      hi_q      <= 1'b0;
      lo_q      <= 1'b0;
      deep_q    <= '0;
      valid_q   <= 1'b0;
    end else begin
      pair_gt_q <= pair_gt_i;
      sat_q     <= sat_i;
      hi_q      <= hi_i;
      lo_q      <= lo_i;
      deep_q    <= deep_i;
      valid_q   <= 1'b1;
    end
  end
endmodule

// File: rtl/eds_argmax.sv
module eds_argmax #(
  parameter int unsigned NOUT = 3,
  localparam int unsigned NPAIR = NOUT * (NOUT - 1) / 2
) (
  input  logic [NPAIR-1:0] gt,
  output logic [NOUT-1:0]  pick
);
  // position of the "hi beats lo" bit, lo < hi
  function automatic int pidx(int lo, int hi);
    return hi * (hi - 1) / 2 + lo;
  endfunction

  // bits that must be set for candidate k: k beats every lower index
  function automatic logic [NPAIR-1:0] beat_mask(int k);
    logic [NPAIR-1:0] m;
    logic [NPAIR-1:0] one;
    m = '0;
    one = '0;
    one[0] = 1'b1;
    for (int j = 0; j < k; j++) m = m | (one << pidx(j, k));
    return m;
  endfunction

  // bits that must be clear for candidate k: no higher index beats k
  function automatic logic [NPAIR-1:0] lose_mask(int k);
    logic [NPAIR-1:0] m;
    logic [NPAIR-1:0] one;
    m = '0;
    one = '0;
    one[0] = 1'b1;
    for (int j = k + 1; j < int'(NOUT); j++) m = m | (one << pidx(k, j));
    return m;
  endfunction

  logic [NOUT-1:0] win;

  for (genvar k = 0; k < int'(NOUT); k++) begin : g_cand
    localparam logic [NPAIR-1:0] MSET = beat_mask(k);
    localparam logic [NPAIR-1:0] MCLR = lose_mask(k);
    assign win[k] = ((gt & MSET) == MSET) && ((gt & MCLR) == '0);
  end

  // contradictory comparator set: fall back to output 0
  always_comb begin
    if (win == '0) begin
      pick    = '0;
      pick[0] = 1'b1;
    end else begin
      pick = win;
    end
  end
endmodule

// File: rtl/eds_mode_pick.sv
module eds_mode_pick #(
  parameter int unsigned NOUT = 3
) (
  input  logic              idle,
  input  logic              hi,
  input  logic              lo,
  input  logic [NOUT-1:0]   deep,
  input  logic [NOUT-1:0]   pick,
  output eds_pkg::sw_mode_e mode
);
  import eds_pkg::*;
  always_comb begin
    if (idle)               mode = MODE_A;
    else if (hi)            mode = MODE_B;
    else if (lo)            mode = MODE_A;
    else if (|(deep & pick)) mode = MODE_B;
    else                    mode = MODE_A;
  end
endmodule

// File: rtl/err_drive_sched.sv
module err_drive_sched #(
  parameter int unsigned NOUT = 3,
  localparam int unsigned NPAIR = NOUT * (NOUT - 1) / 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPAIR-1:0] pair_gt,
  input  logic [NOUT-1:0]  err_satisfied,
  input  logic             sum_over_hi,
  input  logic             sum_under_lo,
  input  logic [NOUT-1:0]  deep_boost,
  output logic [NOUT-1:0]  chan_sel,
  output logic             mode_b,
  output logic             freewheel
);
  import eds_pkg::*;

  logic [NPAIR-1:0] gt_q;
  logic [NOUT-1:0]  sat_q;
  logic             hi_q;
  logic             lo_q;
  logic [NOUT-1:0]  deep_q;
  logic             valid_q;
  logic [NOUT-1:0]  pick;
  logic             idle;
  sw_mode_e         mode;

  eds_sampler #(.NOUT(NOUT)) u_smp (
    .clk       (clk),
    .rst_n     (rst_n),
    .pair_gt_i (pair_gt),
    .sat_i     (err_satisfied),
    .hi_i      (sum_over_hi),
    .lo_i      (sum_under_lo),
    .deep_i    (deep_boost),
    .pair_gt_q (gt_q),
    .sat_q     (sat_q),
    .hi_q      (hi_q),
    .lo_q      (lo_q),
    .deep_q    (deep_q),
    .valid_q   (valid_q)
  );

  eds_argmax #(.NOUT(NOUT)) u_max (
    .gt   (gt_q),
    .pick (pick)
  );

  assign idle = !valid_q || (&sat_q);

  eds_mode_pick #(.NOUT(NOUT)) u_mode (
    .idle (idle),
    .hi   (hi_q),
    .lo   (lo_q),
    .deep (deep_q),
    .pick (pick),
    .mode (mode)
  );

  assign freewheel = idle;
  assign chan_sel  = idle ? '0 : pick;
  assign mode_b    = (mode == MODE_B);

  // R11
  sel_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    freewheel ? (chan_sel == '0) : ($countones(chan_sel) == 1));

  // R5
  idle_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    freewheel |-> !mode_b);

  // R6
  boost_band_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!freewheel && hi_q) |-> mode_b);

  // R7
  drop_band_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!freewheel && lo_q && !hi_q) |-> !mode_b);

  // R8
  band_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!freewheel && !hi_q && !lo_q) |-> (mode_b == |(chan_sel & deep_q)));
endmodule

// File: tb/err_drive_sched_test.sv
module err_drive_sched_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] pair_gt;
  logic [2:0] err_satisfied;
  logic       sum_over_hi;
  logic       sum_under_lo;
  logic [2:0] deep_boost;
  logic [2:0] chan_sel;
  logic       mode_b;
  logic       freewheel;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [2:0] exp_sel, nxt_sel;
  logic       exp_mode, nxt_mode, exp_fw, nxt_fw;

  always #10 clk = ~clk;

  err_drive_sched #(.NOUT(3)) uut (
    .clk(clk), .rst_n(rst_n), .pair_gt(pair_gt), .err_satisfied(err_satisfied),
    .sum_over_hi(sum_over_hi), .sum_under_lo(sum_under_lo), .deep_boost(deep_boost),
    .chan_sel(chan_sel), .mode_b(mode_b), .freewheel(freewheel)
  );

  task automatic check(input string req);
    checks++;
    if (chan_sel !== exp_sel || mode_b !== exp_mode || freewheel !== exp_fw) begin
      errors++;
      $display("FAIL %s: sel=%b mode=%b fw=%b expected sel=%b mode=%b fw=%b",
               req, chan_sel, mode_b, freewheel, exp_sel, exp_mode, exp_fw);
    end
  endtask

  // behavioural reference: integer errors, first maximum wins
  task automatic model(input int e0, input int e1, input int e2, input bit cyc,
                       input logic [2:0] sat, input logic hi, input logic lo,
                       input logic [2:0] deep);
    int ev[3];
    int best;
    ev[0] = e0; ev[1] = e1; ev[2] = e2;
    best = 0;
    for (int k = 1; k < 3; k++) if (ev[k] > ev[best]) best = k;
    if (cyc) best = 0;
    nxt_fw = (sat == 3'b111);
    if (nxt_fw) begin
      nxt_sel = 3'b000;
      nxt_mode = 1'b0;
    end else begin
      nxt_sel = 3'b001 << best;
      if (hi) nxt_mode = 1'b1;
      else if (lo) nxt_mode = 1'b0;
      else nxt_mode = deep[best];
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic apply(input int e0, input int e1, input int e2, input bit cyc,
                       input logic [2:0] cbits, input logic [2:0] sat,
                       input logic hi, input logic lo, input logic [2:0] deep,
                       input string pre_tag, input string tag);
    pair_gt       = cyc ? cbits : {e2 > e1, e2 > e0, e1 > e0};
    err_satisfied = sat;
    sum_over_hi   = hi;
    sum_under_lo  = lo;
    deep_boost    = deep;
    model(e0, e1, e2, cyc, sat, hi, lo, deep);
    #5 check(pre_tag);
    @(negedge clk);
    exp_sel = nxt_sel; exp_mode = nxt_mode; exp_fw = nxt_fw;
    check(tag);
  endtask

  initial begin
    rst_n = 1'b0;
    pair_gt = '0; err_satisfied = '0; sum_over_hi = 0; sum_under_lo = 0; deep_boost = '0;
    exp_sel = 3'b000; exp_mode = 1'b0; exp_fw = 1'b1;
    repeat (3) @(negedge clk);
    check("R10");
    rst_n = 1'b1;
    apply(3, 1, 2, 0, 3'b000, 3'b000, 0, 0, 3'b000, "R10", "R2");
    apply(0, 5, 2, 0, 3'b000, 3'b001, 0, 0, 3'b010, "R1", "R8");
    apply(1, 2, 7, 0, 3'b000, 3'b000, 0, 0, 3'b011, "R1", "R8");
    apply(4, 4, 1, 0, 3'b000, 3'b000, 0, 0, 3'b000, "R1", "R3");
    apply(1, 6, 6, 0, 3'b000, 3'b000, 0, 0, 3'b000, "R1", "R3");
    apply(0, 9, 9, 1, 3'b101, 3'b000, 0, 0, 3'b000, "R1", "R4");
    apply(9, 0, 9, 1, 3'b010, 3'b000, 0, 0, 3'b000, "R1", "R4");
    apply(0, 0, 9, 0, 3'b000, 3'b111, 1, 0, 3'b111, "R1", "R5");
    apply(0, 0, 9, 0, 3'b000, 3'b110, 0, 0, 3'b000, "R1", "R5");
    apply(0, 0, 9, 0, 3'b000, 3'b000, 1, 0, 3'b000, "R1", "R6");
    apply(2, 9, 0, 0, 3'b000, 3'b000, 0, 1, 3'b111, "R1", "R7");
    apply(5, 2, 3, 0, 3'b000, 3'b000, 1, 1, 3'b000, "R1", "R9");
    for (int n = 0; n < 150; n++) begin
      logic [2:0] sat;
      sat = ($urandom_range(0, 4) == 0) ? 3'b111 : 3'($urandom);
      apply(int'($urandom_range(0, 3)), int'($urandom_range(0, 3)),
            int'($urandom_range(0, 3)), 0, 3'b000, sat,
            1'($urandom), 1'($urandom), 3'($urandom), "R1", "R11");
    end
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule